// File: doc/BRIEF.md
# Secondary Miss Status Table

This block keeps track of second-level cache misses that are still waiting for memory. Each request brings a physical address, a flag that says whether the miss wants an exclusive (writable) copy or a shared copy, the way picked for replacement, and the coherence bits of that victim way's tag. The table answers one cycle later with one of four codes:

- a new entry was taken;
- the miss joins an entry already in flight;
- the miss must be retried because it collides with a live entry;
- the table has no free entry.

For the first two codes it also gives the entry number.

An entry stays live until its number is presented on the release port. A release and a request may come in the same cycle. The release takes effect first, so the request sees the table without that entry and may take it over. A flag reports when the table holds nothing. A read port returns everything stored in one entry one cycle after the entry number is given. An entry holds the address, the command, the set, the way, the start stamp, the prior victim state, and the count of merged requests.

Top module: `miss_table`

## Requirements
- R1: An accepted request (req_valid and req_ready high at a rising edge) gives exactly one response in the following cycle. With no live entry in the same set, it takes the lowest-numbered free entry and answers code 0 (allocated) with that entry number. rsp_valid is low in cycles that follow no accepted request.
- R2: A request whose line address equals a live entry's line answers code 1 (merged) with that entry's number. Each merge adds one to that entry's waiting count.
- R3: A request whose set matches a live entry but whose line differs answers code 2 (conflict) with the live entry's number.
- R4: An exclusive request to the line of a live shared-read entry answers code 2 (conflict). A shared request to a live exclusive entry merges.
- R5: With all entries live and no set match, the answer is code 3 (full) with entry number 0.
- R6: On allocation the prior victim state is recorded as 0 (invalid) when the victim's invalid bit is set. Otherwise it is 2 (dirty-exclusive) when its exclusive bit is set, and 1 (shared) when neither bit is set.
- R7: With the default 64-byte lines and 256 sets, the set is address bits [13:6]. The line compare ignores bits [5:0].
- R8: A release in the same cycle as a request is applied first. The released entry is neither matched nor treated as busy, and the released entry may be allocated.
- R9: After reset, empty is high, rsp_valid is low and req_ready is high. empty is high exactly when no entry is live.
- R10: The start stamp is taken from a free-running cycle counter. Two allocations accepted N cycles apart have stamps that differ by N.
- R11: A newly allocated entry has a waiting count of zero.
- R12: The read port returns the busy bit and the stored address, command, set, way, stamp, prior state and waiting count of entry rd_idx one cycle after rd_idx is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Table can accept a request |
| req_addr | input | ADDR_W | Physical address of the miss |
| req_excl | input | 1 | 1 = exclusive read, 0 = shared read |
| req_way | input | log2(WAYS) | Replacement way chosen for the fill |
| req_victim_inv | input | 1 | Victim tag invalid bit |
| req_victim_excl | input | 1 | Victim tag exclusive bit |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 0 allocated, 1 merged, 2 conflict, 3 full |
| rsp_idx | output | log2(ENTRIES) | Entry number |
| free_valid | input | 1 | Release an entry |
| free_idx | input | log2(ENTRIES) | Entry to release |
| empty | output | 1 | No live entries |
| rd_idx | input | log2(ENTRIES) | Entry to read |
| rd_busy | output | 1 | Entry is live |
| rd_addr | output | ADDR_W | Stored address |
| rd_excl | output | 1 | Stored command |
| rd_set | output | log2(SETS) | Stored set |
| rd_way | output | log2(WAYS) | Stored victim way |
| rd_stamp | output | STAMP_W | Start cycle stamp |
| rd_state | output | 2 | Prior victim state |
| rd_wait | output | WAIT_W | Merged request count |

## Verification
The assertions check several properties on every cycle:
- each accepted request gets one response and a cycle with no accepted request gets none;
- an allocated entry was free, or released, the cycle before;
- a merge names a live entry;
- a full answer only follows a cycle with every entry live and no release;
- a release names a live entry;
- the empty flag agrees with the busy vector.

Other behaviour can only be shown by the bench's scenarios. This covers the choice between merge and conflict by line and command, the victim-state encoding, and the release-before-request ordering. It also covers the spacing of the stamps and the stored fields seen through the read port.

// File: rtl/smt_pkg.sv
package smt_pkg;
  typedef enum logic [1:0] {
    RES_ALLOC    = 2'd0,
    RES_MERGE    = 2'd1,
    RES_CONFLICT = 2'd2,
    RES_FULL     = 2'd3
  } res_e;

  typedef enum logic [1:0] {
    VST_INVALID = 2'd0,
    VST_SHARED  = 2'd1,
    VST_DIRTY   = 2'd2
  } vstate_e;
endpackage

// File: rtl/smt_first.sv
// Lowest set bit finder.
module smt_first #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/smt_lookup.sv
// Parallel compare of a request against every live entry.
module smt_lookup #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 6,
  parameter int IDX_W   = 8
) (
  input  logic [ENTRIES-1:0] live,
  input  logic [ADDR_W-1:0]  ent_addr [ENTRIES],
  input  logic [ADDR_W-1:0]  req_addr,
  output logic [ENTRIES-1:0] set_hit,
  output logic [ENTRIES-1:0] line_hit
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign set_hit[e]  = live[e] &&
      (ent_addr[e][OFF_W +: IDX_W] == req_addr[OFF_W +: IDX_W]);
    assign line_hit[e] = live[e] &&
      (ent_addr[e][ADDR_W-1:OFF_W] == req_addr[ADDR_W-1:OFF_W]);
  end
endmodule

// File: rtl/miss_table.sv
module miss_table #(
  parameter int ENTRIES    = 8,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 256,
  parameter int WAYS       = 4,
  parameter int STAMP_W    = 16,
  parameter int WAIT_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic                        req_excl,
  input  logic [$clog2(WAYS)-1:0]     req_way,
  input  logic                        req_victim_inv,
  input  logic                        req_victim_excl,
  output logic                        rsp_valid,
  output logic [1:0]                  rsp_code,
  output logic [$clog2(ENTRIES)-1:0]  rsp_idx,
  input  logic                        free_valid,
  input  logic [$clog2(ENTRIES)-1:0]  free_idx,
  output logic                        empty,
  input  logic [$clog2(ENTRIES)-1:0]  rd_idx,
  output logic                        rd_busy,
  output logic [ADDR_W-1:0]           rd_addr,
  output logic                        rd_excl,
  output logic [$clog2(SETS)-1:0]     rd_set,
  output logic [$clog2(WAYS)-1:0]     rd_way,
  output logic [STAMP_W-1:0]          rd_stamp,
  output logic [1:0]                  rd_state,
  output logic [WAIT_W-1:0]           rd_wait
);
  import smt_pkg::*;

  localparam int EW    = $clog2(ENTRIES);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int WW    = $clog2(WAYS);
  localparam int CW    = $clog2(ENTRIES + 1);

  // Entry state
  logic [ENTRIES-1:0] busy_q;
  logic [ADDR_W-1:0]  addr_q  [ENTRIES];
  logic               excl_q  [ENTRIES];
  logic [IDX_W-1:0]   set_q   [ENTRIES];
  logic [WW-1:0]      way_q   [ENTRIES];
  logic [STAMP_W-1:0] stamp_q [ENTRIES];
  logic [1:0]         state_q [ENTRIES];
  logic [WAIT_W-1:0]  wait_q  [ENTRIES];
  logic [CW-1:0]      count_q, count_nxt;
  logic [STAMP_W-1:0] cycle_q;

  // Release is applied before lookup
  logic [ENTRIES-1:0] free_vec, live;
  always_comb begin
    free_vec = '0;
    if (free_valid) free_vec[free_idx] = 1'b1;
  end
  assign live = busy_q & ~free_vec;

  logic [ENTRIES-1:0] set_hit, line_hit;
  smt_lookup #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
  ) u_lookup (
    .live(live), .ent_addr(addr_q), .req_addr(req_addr),
    .set_hit(set_hit), .line_hit(line_hit)
  );

  logic          hit_any, has_free;
  logic [EW-1:0] hit_idx, free_slot;
  smt_first #(.N(ENTRIES), .IW(EW)) u_hit  (.vec(set_hit), .found(hit_any),  .idx(hit_idx));
  smt_first #(.N(ENTRIES), .IW(EW)) u_slot (.vec(~live),   .found(has_free), .idx(free_slot));

  // Classification
  res_e          res;
  logic [EW-1:0] res_idx;
  always_comb begin
    if (hit_any) begin
      res_idx = hit_idx;
      if (line_hit[hit_idx] && !(!excl_q[hit_idx] && req_excl)) res = RES_MERGE;
      else res = RES_CONFLICT;
    end else if (has_free) begin
      res     = RES_ALLOC;
      res_idx = free_slot;
    end else begin
      res     = RES_FULL;
      res_idx = '0;
    end
  end

  logic fire, do_alloc, do_merge;
  assign fire     = req_valid && req_ready;
  assign do_alloc = fire && (res == RES_ALLOC);
  assign do_merge = fire && (res == RES_MERGE);

  vstate_e new_state;
  always_comb begin
    if (req_victim_inv)       new_state = VST_INVALID;
    else if (req_victim_excl) new_state = VST_DIRTY;
    else                      new_state = VST_SHARED;
  end

  assign count_nxt = count_q - CW'(free_valid) + CW'(do_alloc);

  // Control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= '0;
      count_q   <= '0;
      cycle_q   <= '0;
      req_ready <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_code  <= 2'd0;
      rsp_idx   <= '0;
      empty     <= 1'b1;
    end else begin
      cycle_q   <= cycle_q + 1'b1;
      req_ready <= 1'b1;
      rsp_valid <= fire;
      if (fire) begin
        rsp_code <= res;
        rsp_idx  <= res_idx;
      end
      busy_q <= live;
      if (do_alloc) busy_q[free_slot] <= 1'b1;
      count_q <= count_nxt;
      empty   <= (count_nxt == '0);
    end
  end

  // Entry storage, indexed writes only
  always_ff @(posedge clk) begin
    if (do_alloc) begin
      addr_q[free_slot]  <= req_addr;
      excl_q[free_slot]  <= req_excl;
      set_q[free_slot]   <= req_addr[OFF_W +: IDX_W];
      way_q[free_slot]   <= req_way;
      stamp_q[free_slot] <= cycle_q;
      state_q[free_slot] <= new_state;
      wait_q[free_slot]  <= '0;
    end
    if (do_merge && (wait_q[hit_idx] != {WAIT_W{1'b1}}))
      wait_q[hit_idx] <= wait_q[hit_idx] + 1'b1;
  end

  // Registered read port
  always_ff @(posedge clk) begin
    rd_busy  <= busy_q[rd_idx];
    rd_addr  <= addr_q[rd_idx];
    rd_excl  <= excl_q[rd_idx];
    rd_set   <= set_q[rd_idx];
    rd_way   <= way_q[rd_idx];
    rd_stamp <= stamp_q[rd_idx];
    rd_state <= state_q[rd_idx];
    rd_wait  <= wait_q[rd_idx];
  end
endmodule

// File: rtl/miss_table_chk.sv
module miss_table_chk #(
  parameter int ENTRIES = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic                       rsp_valid,
  input logic [1:0]                 rsp_code,
  input logic [$clog2(ENTRIES)-1:0] rsp_idx,
  input logic                       free_valid,
  input logic [$clog2(ENTRIES)-1:0] free_idx,
  input logic                       empty,
  input logic [ENTRIES-1:0]         busy_q
);
  logic [ENTRIES-1:0] prev_busy, prev_freed;
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_busy  <= '0;
      prev_freed <= '0;
    end else begin
      prev_busy  <= busy_q;
      prev_freed <= '0;
      if (free_valid) prev_freed[free_idx] <= 1'b1;
    end
  end

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);

  assert_alloc_slot_free_R1: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 2'd0) |->
      (busy_q[rsp_idx] && (!prev_busy[rsp_idx] || prev_freed[rsp_idx])));

  assert_merge_live_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 2'd1) |-> busy_q[rsp_idx]);

  assert_full_all_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 2'd3) |-> ((&prev_busy) && (prev_freed == '0)));

  assert_free_live_R8: assert property (@(posedge clk) disable iff (rst)
    free_valid |-> busy_q[free_idx]);

  assert_empty_tracks_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (empty == (busy_q == '0)));
endmodule

bind miss_table miss_table_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_idx(rsp_idx),
  .free_valid(free_valid), .free_idx(free_idx), .empty(empty), .busy_q(busy_q)
);

// File: tb/miss_table_test.sv
module miss_table_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_excl = 1'b0;
  logic [1:0]  req_way = '0;
  logic        req_victim_inv = 1'b0;
  logic        req_victim_excl = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [2:0]  rsp_idx;
  logic        free_valid = 1'b0;
  logic [2:0]  free_idx = '0;
  logic        empty;
  logic [2:0]  rd_idx = '0;
  logic        rd_busy;
  logic [31:0] rd_addr;
  logic        rd_excl;
  logic [7:0]  rd_set;
  logic [1:0]  rd_way;
  logic [15:0] rd_stamp;
  logic [1:0]  rd_state;
  logic [3:0]  rd_wait;

  miss_table uut (.*);

  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model
  bit          m_busy [8];
  logic [31:0] m_addr [8];
  bit          m_excl [8];

  logic [4:0] exp_q[$];
  string      tag_q[$];

  // Monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected response", {rsp_code, rsp_idx}, 0);
      end else begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rsp_code, rsp_idx} == e, t, {rsp_code, rsp_idx}, e);
      end
    end
  end

  task automatic step(input bit do_req, input logic [31:0] a, input bit ex,
                      input logic [1:0] way, input bit vinv, input bit vex,
                      input bit do_free, input logic [2:0] fidx, input string tag);
    @(negedge clk);
    req_valid = do_req; req_addr = a; req_excl = ex; req_way = way;
    req_victim_inv = vinv; req_victim_excl = vex;
    free_valid = do_free; free_idx = fidx;
    if (do_free) m_busy[fidx] = 0;
    if (do_req) begin
      int hit = -1;
      int slot = -1;
      logic [1:0] code;
      logic [2:0] idx;
      for (int e = 0; e < 8; e++)
        if (m_busy[e] && m_addr[e][13:6] == a[13:6]) hit = e;
      for (int e = 7; e >= 0; e--)
        if (!m_busy[e]) slot = e;
      if (hit >= 0) begin
        idx = 3'(hit);
        if (m_addr[hit][31:6] == a[31:6] && !(!m_excl[hit] && ex)) code = 2'd1;
        else code = 2'd2;
      end else if (slot >= 0) begin
        code = 2'd0; idx = 3'(slot);
        m_busy[slot] = 1; m_addr[slot] = a; m_excl[slot] = ex;
      end else begin
        code = 2'd3; idx = 3'd0;
      end
      exp_q.push_back({code, idx});
      tag_q.push_back(tag);
    end
    @(negedge clk);
    req_valid = 0; free_valid = 0;
  endtask

  task automatic read_entry(input logic [2:0] i);
    @(negedge clk);
    rd_idx = i;
    @(negedge clk);
  endtask

  int c_a, c_b;
  logic [15:0] s_a;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(empty == 1'b1, "R9 empty after reset", empty, 1);
    check(rsp_valid == 1'b0, "R9 no response after reset", rsp_valid, 0);
    check(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);

    step(1, 32'h1000, 0, 2'd1, 1, 0, 0, 0, "R1 first allocation");
    check(empty == 1'b0, "R9 not empty with live entry", empty, 0);
    read_entry(0);
    check(rd_busy && rd_addr == 32'h1000 && !rd_excl, "R12 stored address", rd_addr, 32'h1000);
    check(rd_set == 8'h40, "R7 set bits", rd_set, 8'h40);
    check(rd_way == 2'd1, "R12 stored way", rd_way, 1);
    check(rd_state == 2'd0, "R6 invalid victim", rd_state, 0);
    check(rd_wait == 4'd0, "R11 wait starts at zero", rd_wait, 0);

    step(1, 32'h103C, 0, 2'd0, 0, 0, 0, 0, "R7 low bits ignored, merge");
    read_entry(0);
    check(rd_wait == 4'd1, "R2 merge bumps wait count", rd_wait, 1);
    step(1, 32'h1010, 1, 2'd0, 0, 0, 0, 0, "R4 exclusive vs shared conflict");
    step(1, 32'h5000, 0, 2'd0, 0, 0, 0, 0, "R3 same set other line");

    step(1, 32'h2000, 1, 2'd2, 0, 1, 0, 0, "R1 second allocation");
    step(1, 32'h2020, 0, 2'd0, 0, 0, 0, 0, "R4 shared vs exclusive merges");
    read_entry(1);
    check(rd_state == 2'd2, "R6 dirty victim", rd_state, 2);
    check(rd_excl == 1'b1 && rd_wait == 4'd1, "R12 excl and wait", {rd_excl, rd_wait}, 5'h11);

    for (int k = 0; k < 6; k++)
      step(1, 32'h3000 + 32'(k) * 32'h40, 0, 2'd3, 0, 0, 0, 0, "R1 fill");
    read_entry(2);
    check(rd_state == 2'd1, "R6 shared victim", rd_state, 1);

    step(1, 32'h8400, 0, 2'd0, 0, 0, 0, 0, "R5 table full");
    step(1, 32'h8400, 0, 2'd0, 0, 0, 1, 3'd3, "R8 release then allocate");
    step(1, 32'h1000, 1, 2'd0, 0, 0, 1, 3'd0, "R8 released entry not matched");
    read_entry(0);
    check(rd_excl == 1'b1 && rd_wait == 4'd0, "R8 entry 0 reallocated", {rd_excl, rd_wait}, 5'h10);

    step(0, 0, 0, 0, 0, 0, 1, 3'd5, "R8 release");
    step(0, 0, 0, 0, 0, 0, 1, 3'd6, "R8 release");
    c_a = cyc;
    step(1, 32'h8800, 0, 2'd0, 0, 0, 0, 0, "R10 stamp A");
    repeat (4) @(negedge clk);
    c_b = cyc;
    step(1, 32'h8C00, 0, 2'd0, 0, 0, 0, 0, "R10 stamp B");
    read_entry(5);
    s_a = rd_stamp;
    read_entry(6);
    check(rd_stamp - s_a == 16'(c_b - c_a), "R10 stamp spacing", rd_stamp - s_a, c_b - c_a);

    for (int e = 0; e < 7; e++) step(0, 0, 0, 0, 0, 0, 1, 3'(e), "R8 release");
    check(empty == 1'b0, "R9 one entry left", empty, 0);
    step(0, 0, 0, 0, 0, 0, 1, 3'd7, "R8 release");
    check(empty == 1'b1, "R9 empty after all released", empty, 1);
    read_entry(7);
    check(rd_busy == 1'b0, "R8 released entry idle", rd_busy, 0);

    @(negedge clk);
    check(exp_q.size() == 0, "R1 responses outstanding", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule